// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block is an eight-pin general-purpose I/O port sitting behind a small memory-mapped register window of 4 KB. Its only data register is reached through a 1 KB aperture at the bottom of the window. Within that aperture the word address itself acts as a per-pin mask: address bits [9:2] choose which pins a read returns and which pins a write may change. Software can therefore set or clear a single pin, or any group of pins, in one store. It needs no read-modify-write sequence and no separate set or clear registers.

A direction register picks, per pin, whether the pin is driven by the port (output) or sampled from outside (input). Input pins pass through a two-flop synchronizer before they reach the data register. Output pins carry their data bit. Pins configured as inputs leave their output line high. The port also produces two per-pin change vectors. One marks output lines that changed level. The other marks input data bits that changed, and is meant for an interrupt unit. The bus side is a single-cycle register interface: writes take effect at the clock edge where select and write are high, and read data is combinational from the address.

Top module: `gpio_mask_port`

## Requirements
- R1: A read at a byte offset below 0x400 returns the data register ANDed with mask = offset[9:2] in bits [7:0]; bits [31:8] and every unmasked bit read as 0. Offset bits [1:0] are ignored inside this aperture.
- R2: A write at a byte offset below 0x400 changes data bit i to write-data bit i only when offset bit i+2 is 1 and direction bit i is 1. Every other data bit keeps its value at that edge.
- R3: The direction register sits at exact offset 0x400. A write there stores write-data bits [7:0] and drops bits [31:8]. A read there returns the stored value zero-extended. A 1 in bit i makes pin i an output.
- R4: Output bit i equals data bit i when direction bit i is 1, and equals 1 when direction bit i is 0.
- R5: While direction bit i is 0, data bit i takes input pin i through two synchronizer flops. A level applied before clock edge 1 is seen by a read after edge 3 and not after edge 2. Input pins whose direction bit is 1 never change the data register.
- R6: The input-change vector has bit i high for exactly one cycle, the cycle after the edge where data bit i changed while direction bit i is 0. It is 0 otherwise.
- R7: The output-change vector has bit i high for exactly one cycle, the cycle after the edge where output bit i changed level. It is 0 otherwise.
- R8: After reset, data and direction are 0, every output bit is 1, both change vectors are 0, and reads return 0.
- R9: Any offset that is neither below 0x400 nor exactly 0x400 reads as 0, and a write to it changes neither data, direction nor the outputs. Offset 0x401 is unmapped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busSel | input | 1 | Register access this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte offset inside the window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational |
| pinIn | input | 8 | Asynchronous input levels from the pins |
| pinOut | output | 8 | Output levels to the pins |
| outChange | output | 8 | One-cycle pulse per output bit that changed |
| inChange | output | 8 | One-cycle pulse per input data bit that changed |

## Verification
The hardest situation to reach is a data bit changing at the same edge a pin changes direction. At that edge the old direction still decides whether the bit follows the synchronizer or a store, and the change pulses must follow the new direction. The bench sets up a stable input level on pins that are outputs, then writes a direction value that turns them into inputs. It then checks the output-change pulse at the direction edge and the input-change pulse one edge later, when the synchronized level overwrites the old stored bits. The synchronizer latency is checked by sampling one edge before and at the edge where a new pin level must first appear.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;

  parameter int unsigned PIN_W = 8;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_DATA = 2'd1,
    RD_DIR  = 2'd2
  } rdSel_t;

  typedef struct packed {
    logic             dataWr;
    logic             dirWr;
    logic [PIN_W-1:0] mask;
    logic [PIN_W-1:0] wdata;
    rdSel_t           rdSel;
  } ctrlStrobes_t;

endpackage

// File: rtl/gpio_mask_sync.sv
module gpio_mask_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[0] <= '0;
          else       stage[0] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[s] <= '0;
          else       stage[s] <= stage[s-1];
        end
        // R5
        stage_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
          1'b1 |=> (stage[s] == $past(stage[s-1])));
      end
    end
  endgenerate

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/gpio_mask_ctrl.sv
module gpio_mask_ctrl
  import gpio_mask_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output ctrlStrobes_t      strobes
);

  localparam int unsigned APERTURE_BITS = PIN_W + 2;
  localparam logic [ADDR_W-1:0] DIR_OFFSET = ADDR_W'(1) << APERTURE_BITS;

  logic inAperture;
  logic isDir;
  logic unusedBits;

  assign inAperture = (busAddr[ADDR_W-1:APERTURE_BITS] == '0);
  assign isDir      = (busAddr == DIR_OFFSET);
  assign unusedBits = ^{busWdata[DATA_W-1:PIN_W], busAddr[1:0]};

  always_comb begin
    strobes        = '0;
    strobes.mask   = busAddr[APERTURE_BITS-1:2];
    strobes.wdata  = busWdata[PIN_W-1:0];
    strobes.dataWr = busSel && busWr && inAperture;
    strobes.dirWr  = busSel && busWr && isDir;
    if (inAperture)  strobes.rdSel = RD_DATA;
    else if (isDir)  strobes.rdSel = RD_DIR;
    else             strobes.rdSel = RD_NONE;
  end

  // R9
  unmapped_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !inAperture && !isDir) |-> (!strobes.dataWr && !strobes.dirWr && strobes.rdSel == RD_NONE));

  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.dataWr && strobes.dirWr));

endmodule

// File: rtl/gpio_mask_datapath.sv
module gpio_mask_datapath
  import gpio_mask_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic [PIN_W-1:0] syncIn,
  output logic [PIN_W-1:0] pinOut,
  output logic [PIN_W-1:0] outChange,
  output logic [PIN_W-1:0] inChange,
  output logic [PIN_W-1:0] rdData
);

  logic [PIN_W-1:0] dataReg;
  logic [PIN_W-1:0] dirReg;
  logic [PIN_W-1:0] prevOut;
  logic [PIN_W-1:0] prevIn;
  logic [PIN_W-1:0] wrMask;
  logic [PIN_W-1:0] dataNext;

  assign wrMask = strobes.dataWr ? (strobes.mask & dirReg) : '0;

  always_comb begin
    dataNext = (dataReg & dirReg) | (syncIn & ~dirReg);
    dataNext = (dataNext & ~wrMask) | (strobes.wdata & wrMask);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg <= '0;
      dirReg  <= '0;
      prevOut <= '1;
      prevIn  <= '0;
    end else begin
      dataReg <= dataNext;
      if (strobes.dirWr) dirReg <= strobes.wdata;
      prevOut <= pinOut;
      prevIn  <= dataReg;
    end
  end

  assign pinOut    = (dataReg & dirReg) | ~dirReg;
  assign outChange = pinOut ^ prevOut;
  assign inChange  = (dataReg ^ prevIn) & ~dirReg;

  always_comb begin
    case (strobes.rdSel)
      RD_DATA: rdData = dataReg & strobes.mask;
      RD_DIR:  rdData = dirReg;
      default: rdData = '0;
    endcase
  end

  // R3
  dir_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.dirWr |=> (dirReg == $past(strobes.wdata)));

  // R2
  out_bits_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.dataWr |=> (((dataReg ^ $past(dataReg)) & $past(dirReg)) == '0));

  // R2
  masked_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.dataWr |=> (((dataReg ^ $past(dataReg)) & $past(dirReg) & ~$past(strobes.mask)) == '0));

  // R4
  out_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.dataWr && !strobes.dirWr) |=> $stable(pinOut));

endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpio_mask_pkg::*;
#(
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [PIN_W-1:0]  pinIn,
  output logic [PIN_W-1:0]  pinOut,
  output logic [PIN_W-1:0]  outChange,
  output logic [PIN_W-1:0]  inChange
);

  ctrlStrobes_t     strobes;
  logic [PIN_W-1:0] syncIn;
  logic [PIN_W-1:0] rdData;

  gpio_mask_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .asyncIn(pinIn), .syncOut(syncIn)
  );

  gpio_mask_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .strobes(strobes)
  );

  gpio_mask_datapath uPath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .syncIn(syncIn),
    .pinOut(pinOut), .outChange(outChange), .inChange(inChange), .rdData(rdData)
  );

  assign busRdata = {{(DATA_W-PIN_W){1'b0}}, rdData};

endmodule

// File: tb/gpio_mask_port_test.sv
`timescale 1ns/1ps
module gpio_mask_port_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [7:0]  pinIn = '0;
  logic [7:0]  pinOut;
  logic [7:0]  outChange;
  logic [7:0]  inChange;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_mask_port uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .pinIn(pinIn), .pinOut(pinOut), .outChange(outChange), .inChange(inChange)
  );

  // {dir, write mask, write value, read mask, expected pinOut, expected read}
  localparam logic [47:0] VEC [4] = '{
    48'hF0_FF_A5_FF_AF_A0,
    48'hF0_30_FF_3C_BF_30,
    48'hFF_0F_05_C3_B5_81,
    48'h0F_FF_3C_FF_FC_0C
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [11:0] a, output logic [31:0] d);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 d = busRdata;
    busSel = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R8 reset state
    check("R8 pinOut", {24'b0, pinOut}, 32'hFF);
    check("R8 outChange", {24'b0, outChange}, 32'h0);
    check("R8 inChange", {24'b0, inChange}, 32'h0);
    busRead(12'h400, rd); check("R8 dir read", rd, 32'h0);
    busRead(12'h3FC, rd); check("R8 data read", rd, 32'h0);

    // Table walk: R1 R2 R3 R4
    for (int i = 0; i < 4; i++) begin
      busWrite(12'h400, {24'b0, VEC[i][47:40]});
      busWrite({2'b00, VEC[i][39:32], 2'b00}, {24'hABCDEF, VEC[i][31:24]});
      check("R4 table pinOut", {24'b0, pinOut}, {24'b0, VEC[i][15:8]});
      busRead({2'b00, VEC[i][23:16], 2'b00}, rd);
      check("R1 R2 table read", rd, {24'b0, VEC[i][7:0]});
    end

    // R2 write to input pins ignored (dir=0F)
    busWrite(12'h3C0, 32'hF0);
    busRead(12'h3FC, rd); check("R2 input bits unwritten", rd, 32'h0C);
    // R1 zero mask, single-bit mask, low offset bits ignored
    busRead(12'h000, rd); check("R1 zero mask", rd, 32'h0);
    busRead(12'h013, rd); check("R1 single bit mask", rd, 32'h04);

    // R5 synchronizer latency, R6 input change pulse
    @(negedge clk); pinIn = 8'hA0;
    repeat (2) @(negedge clk);
    busRead(12'h3C0, rd); check("R5 not yet visible", rd, 32'h0);
    check("R6 no early pulse", {24'b0, inChange}, 32'h0);
    @(negedge clk);
    check("R6 pulse", {24'b0, inChange}, 32'hA0);
    busRead(12'h3C0, rd); check("R5 visible after 3 edges", rd, 32'hA0);
    @(negedge clk);
    check("R6 pulse one cycle", {24'b0, inChange}, 32'h0);

    // R5 input level on output pins ignored
    @(negedge clk); pinIn = 8'hAF;
    repeat (3) @(negedge clk);
    busRead(12'h3FC, rd); check("R5 output pins keep data", rd, 32'hAC);
    check("R6 no pulse on output pins", {24'b0, inChange}, 32'h0);

    // R7 output change pulse
    busWrite(12'h03C, 32'h03);
    check("R7 out pulse", {24'b0, outChange}, 32'h0F);
    check("R4 pinOut after write", {24'b0, pinOut}, 32'hF3);
    @(negedge clk);
    check("R7 out pulse one cycle", {24'b0, outChange}, 32'h0);

    // R9 unmapped offsets
    busWrite(12'h404, 32'hFF);
    busWrite(12'h401, 32'hFF);
    busWrite(12'hFFC, 32'hFF);
    busRead(12'h400, rd); check("R9 dir untouched", rd, 32'h0F);
    check("R9 pinOut untouched", {24'b0, pinOut}, 32'hF3);
    busRead(12'h3FC, rd); check("R9 data untouched", rd, 32'hA3);
    busRead(12'h404, rd); check("R9 read 0x404", rd, 32'h0);
    busRead(12'h401, rd); check("R9 read 0x401", rd, 32'h0);
    busRead(12'hFFC, rd); check("R9 read 0xFFC", rd, 32'h0);

    // R3 upper bits dropped; direction turn-around (R4 R6 R7)
    busWrite(12'h400, 32'hFFFF_FF00);
    busRead(12'h400, rd); check("R3 low byte only", rd, 32'h0);
    check("R4 all inputs high", {24'b0, pinOut}, 32'hFF);
    check("R7 pulse on turn-around", {24'b0, outChange}, 32'h0C);
    check("R6 no pulse at dir edge", {24'b0, inChange}, 32'h0);
    @(negedge clk);
    check("R6 pulse after turn-around", {24'b0, inChange}, 32'h0C);
    busRead(12'h3FC, rd); check("R5 follows pins", rd, 32'hAF);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule